// File: doc/BRIEF.md
# RC Oscillator Frequency Calibrator

This block trims an on-chip fast RC oscillator against a crystal reference clock. A run opens a counting window that lasts a programmable number of crystal cycles. It counts RC-clock pulses inside that window and compares the total against a fixed target of 200. The window length is chosen so that an oscillator on its nominal frequency yields exactly that target. A 7-bit trim code drives the oscillator's frequency control, and a higher code gives a faster clock. Each run settles the code with a binary search, starting at the most significant bit and taking one gated measurement per bit.

A run can be requested in three ways: the power-on initialisation request, the self-check request and the host command request. Each one is qualified by its own enable input. Requests that arrive while a run is active fold into one pending request, which starts exactly one more run. A busy flag covers the whole run and ends with a one-cycle done pulse. A completion event is raised alongside that pulse only when the event mask input is set. The pulse counter runs in the RC clock domain. Its result reaches the crystal domain through a toggle handshake.

Top module: `rc_osc_calibrator`

## Requirements
- R1: The trim code is 7 bits and a higher code raises the frequency. A run tests bits from bit 6 down to bit 0. The bit under test is set during its measurement and is kept only if the count is at most 200. If every count exceeds 200 the result is 0, and if every count is at or below 200 the result is 127.
- R2: The counting window stays open for exactly `gate_len` crystal cycles. `meas_count` reports the number of RC pulses counted inside the last window.
- R3: An oscillator that starts within ±5% of nominal ends a run within ±2% of nominal, given a gate value that makes nominal equal to 200 pulses.
- R4: A power-on request starts a run only while `por_en` is 1. Otherwise it changes neither `busy` nor `trim`.
- R5: A self-check request starts a run only while `chk_en` is 1. Otherwise it changes neither `busy` nor `trim`.
- R6: A host command request starts a run only while `host_en` is 1. Otherwise it changes neither `busy` nor `trim`.
- R7: Any number of accepted requests during a busy run merge into one pending request, which starts exactly one further run after the current one.
- R8: `busy` is high from the first cycle of a run through the single-cycle `done` pulse and is low on the cycle after it. `trim` changes only while `busy` is high.
- R9: `cmd_rdy_evt` pulses together with `done` when `evt_mask` is 1 and stays low when it is 0.
- R10: The pulse count saturates at 255 and does not wrap. A grossly fast oscillator therefore ends with `meas_count` = 255 and trim 0.
- R11: A run requested with `gate_len` = 0 opens no window. It pulses `done` on the second clock edge after the request is sampled and leaves `trim` and `meas_count` unchanged.
- R12: After reset, `trim` is 64, `meas_count` is 0, and `busy`, `done` and `cmd_rdy_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Synchronous active-low reset (crystal domain; resynchronised for the RC domain) |
| rc_clk | input | 1 | RC oscillator clock being trimmed |
| gate_len | input | 8 | Counting window length in crystal cycles; 0 aborts a run |
| por_req | input | 1 | Power-on initialisation request pulse |
| por_en | input | 1 | Enable for the power-on request |
| chk_req | input | 1 | Self-check request pulse |
| chk_en | input | 1 | Enable for the self-check request |
| host_req | input | 1 | Host command request pulse |
| host_en | input | 1 | Enable for the host command request |
| evt_mask | input | 1 | Completion event enable |
| trim | output | 7 | Oscillator frequency trim code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_rdy_evt | output | 1 | Masked completion event |
| meas_count | output | 8 | Pulse count from the most recent window |

## Verification
A request pulse is sampled on one crystal edge, which sets the pending flag. The run starts on the next edge, so `busy` (and, for a zero gate, `done`) is observed two edges after the request. The bench drives request pulses at falling edges and reads those outputs at the falling edge after the second rising edge. A full run takes a variable number of cycles, roughly 7 × (gate + synchroniser latency). For that reason the bench polls `done` at every falling edge within a bounded window instead of sampling at a fixed cycle. It checks `busy` in the `done` cycle and again one cycle later. Final trim quality is judged against the bench's own oscillator model, which requires the resulting frequency to lie within ±2% of nominal. Exact codes are expected only where the search outcome is unambiguous (0, 127).

// File: rtl/rcc_pkg.sv
// Shared constants and types for the RC oscillator calibrator.
// Assumes: crystal-domain control, RC-domain counting.
package rcc_pkg;
    localparam int TRIM_W_D = 7;    // trim code width
    localparam int CNT_W_D  = 8;    // pulse counter width
    localparam int GATE_W_D = 8;    // gate length field width
    localparam int TARGET_D = 200;  // pulses expected at nominal frequency
    localparam int SYNC_D   = 2;    // synchroniser depth
    localparam int NSRC     = 3;    // number of trigger sources

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } sar_state_e;
endpackage

// File: rtl/rcc_trigger.sv
// Trigger arbitration: qualifies each request source with its enable,
// merges accepted requests into one pending flag and releases a start
// pulse when the engine is idle. Assumes requests are crystal-domain.
module rcc_trigger #(
    parameter int N_SRC = rcc_pkg::NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    input  logic             busy,
    output logic             run_start
);
    logic [N_SRC-1:0] qualified;
    logic             pending_q;

    // Per-source qualification of a request by its own enable bit.
    for (genvar g = 0; g < N_SRC; g++) begin : g_qual
        assign qualified[g] = req[g] & en[g];
    end

    // Start fires when a request is pending and no run is active.
    assign run_start = pending_q & ~busy;

    // Pending flag: set by any accepted request, cleared when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= (pending_q & ~run_start) | (|qualified);
        end
    end
endmodule

// File: rtl/rcc_gate_timer.sv
// Gate timer: on a go pulse, opens the counting window for exactly
// len crystal cycles. Assumes go is only pulsed with a nonzero len.
module rcc_gate_timer #(
    parameter int GATE_W = rcc_pkg::GATE_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [GATE_W-1:0] len,
    output logic              gate_open
);
    localparam logic [GATE_W-1:0] ONE = GATE_W'(1);

    logic [GATE_W-1:0] remain_q;
    logic              open_q;

    assign gate_open = open_q;

    // Window counter: load on go, count down, close after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q   <= 1'b0;
            remain_q <= '0;
        end else if (go && (len != '0)) begin
            open_q   <= 1'b1;
            remain_q <= len;
        end else if (open_q) begin
            if (remain_q == ONE) begin
                open_q <= 1'b0;
            end
            remain_q <= remain_q - ONE;
        end
    end
endmodule

// File: rtl/rcc_pulse_counter.sv
// Pulse counter across two clock domains. The gate is synchronised into
// the RC domain and RC cycles are counted while it is high, with
// saturation. On gate close the count is frozen and a toggle is flipped.
// The crystal domain synchronises the toggle and flags a valid count.
// Assumes the gate stays low until the valid flag has been seen.
module rcc_pulse_counter #(
    parameter int CNT_W = rcc_pkg::CNT_W_D,
    parameter int SYNC  = rcc_pkg::SYNC_D
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             rc_clk,
    input  logic             gate_open,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [1:0]       rc_rst_pipe;
    logic             rc_rst_n;
    logic [SYNC-1:0]  gate_sync;
    logic             gate_prev;
    logic             gate_rc;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_q;
    logic             tgl_q;
    logic [SYNC-1:0]  tgl_sync;
    logic             tgl_prev;

    // Reset resynchroniser for the RC domain.
    always_ff @(posedge rc_clk) begin
        rc_rst_pipe <= {rc_rst_pipe[0], ref_rst_n};
    end
    assign rc_rst_n = rc_rst_pipe[1];

    // Gate synchroniser chain into the RC domain.
    always_ff @(posedge rc_clk) begin
        if (!rc_rst_n) begin
            gate_sync <= '0;
            gate_prev <= 1'b0;
        end else begin
            gate_sync <= {gate_sync[SYNC-2:0], gate_open};
            gate_prev <= gate_sync[SYNC-1];
        end
    end
    assign gate_rc = gate_sync[SYNC-1];

    // Saturating RC-cycle counter, cleared while the gate is closed.
    always_ff @(posedge rc_clk) begin
        if (!rc_rst_n) begin
            cnt_q <= '0;
        end else if (gate_rc) begin
            cnt_q <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
        end else begin
            cnt_q <= '0;
        end
    end

    // Freeze the count and flip the toggle when the gate closes.
    always_ff @(posedge rc_clk) begin
        if (!rc_rst_n) begin
            hold_q <= '0;
            tgl_q  <= 1'b0;
        end else if (gate_prev && !gate_rc) begin
            hold_q <= cnt_q;
            tgl_q  <= ~tgl_q;
        end
    end

    // Toggle synchroniser and edge detector in the crystal domain.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            tgl_sync <= '0;
            tgl_prev <= 1'b0;
        end else begin
            tgl_sync <= {tgl_sync[SYNC-2:0], tgl_q};
            tgl_prev <= tgl_sync[SYNC-1];
        end
    end

    assign count_valid = tgl_sync[SYNC-1] ^ tgl_prev;
    assign count_out   = hold_q;
endmodule

// File: rtl/rcc_sar_engine.sv
// Trim search engine. For each trim bit from MSB to LSB it sets the bit,
// runs one gated count and keeps the bit if the count is at or below the
// target. A zero gate length finishes at once with the trim untouched.
// Assumes one count_valid pulse per gate go.
module rcc_sar_engine #(
    parameter int TRIM_W = rcc_pkg::TRIM_W_D,
    parameter int CNT_W  = rcc_pkg::CNT_W_D,
    parameter int GATE_W = rcc_pkg::GATE_W_D,
    parameter int TARGET = rcc_pkg::TARGET_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_start,
    input  logic [GATE_W-1:0] gate_len,
    input  logic              count_valid,
    input  logic [CNT_W-1:0]  count_in,
    output logic              gate_go,
    output logic [GATE_W-1:0] gate_len_run,
    output logic [TRIM_W-1:0] trim,
    output logic [CNT_W-1:0]  meas_count,
    output logic              busy,
    output logic              done
);
    import rcc_pkg::*;

    localparam logic [TRIM_W-1:0] MSB_ONLY = {1'b1, {(TRIM_W-1){1'b0}}};
    localparam logic [CNT_W-1:0]  TGT      = CNT_W'(TARGET);

    sar_state_e        state_q;
    logic [TRIM_W-1:0] trim_q;
    logic [TRIM_W-1:0] bit_q;
    logic [TRIM_W-1:0] decided;
    logic [GATE_W-1:0] glen_q;
    logic [CNT_W-1:0]  meas_q;

    assign gate_go      = (state_q == ST_OPEN);
    assign gate_len_run = glen_q;
    assign trim         = trim_q;
    assign meas_count   = meas_q;
    assign busy         = (state_q != ST_IDLE);
    assign done         = (state_q == ST_DONE);

    // Decision for the bit under test: drop it if the count overshoots.
    assign decided = (count_in <= TGT) ? trim_q : (trim_q & ~bit_q);

    // Search state machine and trim register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            trim_q  <= MSB_ONLY;
            bit_q   <= '0;
            glen_q  <= '0;
            meas_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (run_start) begin
                        if (gate_len == '0) begin
                            state_q <= ST_DONE;
                        end else begin
                            glen_q  <= gate_len;
                            trim_q  <= MSB_ONLY;
                            bit_q   <= MSB_ONLY;
                            state_q <= ST_OPEN;
                        end
                    end
                end
                ST_OPEN: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (count_valid) begin
                        meas_q <= count_in;
                        if (bit_q[0]) begin
                            trim_q  <= decided;
                            state_q <= ST_DONE;
                        end else begin
                            trim_q  <= decided | (bit_q >> 1);
                            bit_q   <= bit_q >> 1;
                            state_q <= ST_OPEN;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/rc_osc_calibrator.sv
// Top of the RC oscillator calibrator: trigger arbitration, gate timer,
// two-domain pulse counter and trim search engine, plus event masking.
// Assumes rst_n is synchronous to ref_clk and rc_clk is free-running.
module rc_osc_calibrator #(
    parameter int TRIM_W = rcc_pkg::TRIM_W_D,
    parameter int CNT_W  = rcc_pkg::CNT_W_D,
    parameter int GATE_W = rcc_pkg::GATE_W_D,
    parameter int TARGET = rcc_pkg::TARGET_D,
    parameter int SYNC   = rcc_pkg::SYNC_D
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              rc_clk,
    input  logic [GATE_W-1:0] gate_len,
    input  logic              por_req,
    input  logic              por_en,
    input  logic              chk_req,
    input  logic              chk_en,
    input  logic              host_req,
    input  logic              host_en,
    input  logic              evt_mask,
    output logic [TRIM_W-1:0] trim,
    output logic              busy,
    output logic              done,
    output logic              cmd_rdy_evt,
    output logic [CNT_W-1:0]  meas_count
);
    localparam int N_SRC = rcc_pkg::NSRC;

    logic              run_start;
    logic              gate_go;
    logic              gate_open;
    logic [GATE_W-1:0] gate_len_run;
    logic [CNT_W-1:0]  count_val;
    logic              count_valid;

    rcc_trigger #(.N_SRC(N_SRC)) u_trig (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .req       ({host_req, chk_req, por_req}),
        .en        ({host_en, chk_en, por_en}),
        .busy      (busy),
        .run_start (run_start)
    );

    rcc_gate_timer #(.GATE_W(GATE_W)) u_gate (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .go        (gate_go),
        .len       (gate_len_run),
        .gate_open (gate_open)
    );

    rcc_pulse_counter #(.CNT_W(CNT_W), .SYNC(SYNC)) u_cnt (
        .ref_clk     (ref_clk),
        .ref_rst_n   (rst_n),
        .rc_clk      (rc_clk),
        .gate_open   (gate_open),
        .count_out   (count_val),
        .count_valid (count_valid)
    );

    rcc_sar_engine #(
        .TRIM_W (TRIM_W),
        .CNT_W  (CNT_W),
        .GATE_W (GATE_W),
        .TARGET (TARGET)
    ) u_sar (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .run_start    (run_start),
        .gate_len     (gate_len),
        .count_valid  (count_valid),
        .count_in     (count_val),
        .gate_go      (gate_go),
        .gate_len_run (gate_len_run),
        .trim         (trim),
        .meas_count   (meas_count),
        .busy         (busy),
        .done         (done)
    );

    // Completion event gated by the mask.
    assign cmd_rdy_evt = done & evt_mask;
endmodule

// File: rtl/rcc_checker.sv
// Protocol checker for the calibrator, bound to the top module.
// Assumes rst_n is synchronous to clk.
module rcc_checker #(
    parameter int TRIM_W = rcc_pkg::TRIM_W_D,
    parameter int GATE_W = rcc_pkg::GATE_W_D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [TRIM_W-1:0] trim,
    input logic              gate_open,
    input logic              run_start,
    input logic [GATE_W-1:0] gate_len
);
    // R8
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    trim_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trim) |-> busy);

    // R2
    gate_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> busy);

    // R11
    zero_gate_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && (gate_len == '0)) |=> (done && $stable(trim) && !gate_open));
endmodule

bind rc_osc_calibrator rcc_checker #(.TRIM_W(TRIM_W), .GATE_W(GATE_W)) u_rcc_chk (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .trim      (trim),
    .gate_open (gate_open),
    .run_start (run_start),
    .gate_len  (gate_len)
);

// File: tb/tb_rc_osc_calibrator.sv
`timescale 1ps/1ps
// Bench: a table of trigger/skew vectors walked by one loop, then directed
// tests for reset, gate length, saturation, zero gate and request merging.
// The RC clock is a behavioural model whose frequency follows trim.
module tb_rc_osc_calibrator;
    logic       ref_clk = 1'b0;
    logic       rc_clk  = 1'b0;
    logic       rst_n   = 1'b0;
    logic [7:0] gate_len = 8'd200;
    logic       por_req = 1'b0, por_en = 1'b0;
    logic       chk_req = 1'b0, chk_en = 1'b0;
    logic       host_req = 1'b0, host_en = 1'b0;
    logic       evt_mask = 1'b0;
    logic [6:0] trim;
    logic       busy, done, cmd_rdy_evt;
    logic [7:0] meas_count;

    int  n_chk  = 0;
    int  n_fail = 0;
    real skew   = 0.0;

    rc_osc_calibrator dut (
        .ref_clk (ref_clk), .rst_n (rst_n), .rc_clk (rc_clk),
        .gate_len (gate_len),
        .por_req (por_req), .por_en (por_en),
        .chk_req (chk_req), .chk_en (chk_en),
        .host_req (host_req), .host_en (host_en),
        .evt_mask (evt_mask),
        .trim (trim), .busy (busy), .done (done),
        .cmd_rdy_evt (cmd_rdy_evt), .meas_count (meas_count)
    );

    // 200 MHz crystal reference.
    always #2500 ref_clk = ~ref_clk;

    // Oscillator model: relative frequency for a given trim code.
    function automatic real scale_of(input logic [6:0] t);
        return 1.0 + skew + real'(int'(t) - 64) * 0.0015;
    endfunction

    // RC clock: nominal 200 MHz scaled by the model.
    initial begin
        forever begin
            #(2500.0 / scale_of(trim));
            rc_clk = ~rc_clk;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input int src);
        @(negedge ref_clk);
        case (src)
            0: por_req = 1'b1;
            1: chk_req = 1'b1;
            default: host_req = 1'b1;
        endcase
        @(negedge ref_clk);
        por_req = 1'b0; chk_req = 1'b0; host_req = 1'b0;
    endtask

    // Poll for done; report done count, event count and busy at done.
    task automatic run_wait(input int max, output int dn, output int ev, output bit bz);
        dn = 0; ev = 0; bz = 1'b0;
        for (int k = 0; k < max; k++) begin
            @(negedge ref_clk);
            if (cmd_rdy_evt) ev++;
            if (done) begin
                dn++;
                bz = busy;
                break;
            end
        end
    endtask

    localparam int NV = 8;
    localparam int V_SRC  [NV] = '{0, 1, 2, 0, 1, 2, 2, 2};
    localparam int V_EN   [NV] = '{1, 1, 1, 0, 0, 0, 1, 1};
    localparam int V_SKEW [NV] = '{40, -45, 10, 30, -30, 0, 200, -200}; // per mille
    localparam int V_MASK [NV] = '{1, 0, 1, 1, 1, 1, 0, 1};
    localparam int V_KIND [NV] = '{0, 0, 0, 3, 3, 3, 1, 2};  // 0 tol, 1 min, 2 max, 3 none

    // Watchdog: expiry is a failed check.
    initial begin
        #(64'd750000000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        string src_tag [3] = '{"R4", "R5", "R6"};
        int    dn, ev, tb_b, mb_b;
        bit    bz;
        real   sc;

        repeat (20) @(negedge ref_clk);
        rst_n = 1'b1;
        @(negedge ref_clk);
        // R12: reset state
        check(trim == 7'd64, "R12 trim", trim, 64);
        check(meas_count == 8'd0, "R12 meas_count", meas_count, 0);
        check(!busy && !done && !cmd_rdy_evt, "R12 busy/done/evt", {busy, done, cmd_rdy_evt}, 0);

        // Table walk: trigger sources, enables, skews, event mask.
        for (int i = 0; i < NV; i++) begin
            skew     = real'(V_SKEW[i]) / 1000.0;
            por_en   = (V_SRC[i] == 0) && (V_EN[i] == 1);
            chk_en   = (V_SRC[i] == 1) && (V_EN[i] == 1);
            host_en  = (V_SRC[i] == 2) && (V_EN[i] == 1);
            evt_mask = V_MASK[i][0];
            gate_len = 8'd200;
            tb_b     = trim;
            pulse_req(V_SRC[i]);
            run_wait((V_KIND[i] == 3) ? 800 : 3000, dn, ev, bz);
            if (V_KIND[i] == 3) begin
                check(dn == 0, {src_tag[V_SRC[i]], " disabled request ran"}, dn, 0);
                check(trim == tb_b[6:0] && !busy, {src_tag[V_SRC[i]], " trim kept"}, trim, tb_b);
            end else begin
                check(dn == 1, {src_tag[V_SRC[i]], " enabled request done"}, dn, 1);
                // R8: busy through done, low after
                check(bz, "R8 busy at done", bz, 1);
                @(negedge ref_clk);
                check(!busy && !done, "R8 busy/done after done", {busy, done}, 0);
                // R9: masked event
                check(ev == V_MASK[i], "R9 event count", ev, V_MASK[i]);
                if (V_KIND[i] == 0) begin
                    sc = scale_of(trim);
                    // R3: final frequency within 2 percent
                    check(sc >= 0.98 && sc <= 1.02, "R3 final freq permille",
                          int'(sc * 1000.0), 1000);
                end else if (V_KIND[i] == 1) begin
                    check(trim == 7'd0, "R1 fast osc trim", trim, 0);
                end else begin
                    check(trim == 7'd127, "R1 slow osc trim", trim, 127);
                end
            end
            repeat (10) @(negedge ref_clk);
        end

        // R2: half-length gate gives about half the count; all bits kept.
        por_en = 1'b0; chk_en = 1'b0; host_en = 1'b1; evt_mask = 1'b1;
        skew = 0.0; gate_len = 8'd100;
        pulse_req(2);
        run_wait(3000, dn, ev, bz);
        check(meas_count >= 8'd105 && meas_count <= 8'd113, "R2 gated count", meas_count, 109);
        check(trim == 7'd127, "R1 short gate trim", trim, 127);
        repeat (10) @(negedge ref_clk);

        // R10: saturation at 255 with a grossly fast oscillator.
        skew = 0.5; gate_len = 8'd200;
        pulse_req(2);
        run_wait(3000, dn, ev, bz);
        check(meas_count == 8'd255, "R10 saturated count", meas_count, 255);
        check(trim == 7'd0, "R10 trim", trim, 0);
        repeat (10) @(negedge ref_clk);

        // R11: zero gate aborts on the second edge after the request.
        skew = 0.0; gate_len = 8'd0;
        tb_b = trim; mb_b = meas_count;
        @(negedge ref_clk); host_req = 1'b1;
        @(negedge ref_clk); host_req = 1'b0;
        @(negedge ref_clk);
        check(done == 1'b1, "R11 done timing", done, 1);
        check(cmd_rdy_evt == 1'b1, "R9 event on abort", cmd_rdy_evt, 1);
        @(negedge ref_clk);
        check(!done && !busy, "R11 idle after abort", {done, busy}, 0);
        check(trim == tb_b[6:0], "R11 trim unchanged", trim, tb_b);
        check(meas_count == mb_b[7:0], "R11 count unchanged", meas_count, mb_b);
        repeat (5) @(negedge ref_clk);

        // R7: several requests during a run merge into one extra run.
        gate_len = 8'd200; skew = 0.02; chk_en = 1'b1; host_en = 1'b1;
        pulse_req(2);
        repeat (20) @(negedge ref_clk);
        pulse_req(1);
        repeat (40) @(negedge ref_clk);
        pulse_req(1);
        repeat (40) @(negedge ref_clk);
        pulse_req(2);
        dn = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge ref_clk);
            if (done) dn++;
        end
        check(dn == 2, "R7 merged run count", dn, 2);
        sc = scale_of(trim);
        check(sc >= 0.98 && sc <= 1.02, "R3 after merged runs permille", int'(sc * 1000.0), 1000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule